// File: doc/BRIEF.md
# Zero-Crossing DTMF Tone-Pair Decoder

This block turns two squared tone signals into a DTMF key code. One input carries the low-group band and the other carries the high-group band. Each comes from an external zero-crossing comparator. The block runs on one crystal clock. For each band it counts clock cycles between successive rising edges and compares the count with a period window built around each of the four nominal tones of that band. The nominals are 697, 770, 852 and 941 Hz for the low band and 1209, 1336, 1477 and 1633 Hz for the high band.

A band reports a tone once a run of consecutive periods has all landed in the window of the same tone. When both bands report a tone, the block raises its early-steering flag and presents the 4-bit code of the pair. Guard timing and output latching are left to a downstream block, which reads the flag and the code.

The windows are computed when the design is compiled, from the clock frequency parameter and a tolerance parameter given in per-mille. By default each tone accepts periods whose frequency is within ±2.5% of nominal. This places the window edge between the band that must be accepted (±1.5% ±2 Hz) and the band that must be rejected (±3.5% or more).

Top module: `dtmf_pair_decoder`

## Requirements
- R1: While reset is low, and after reset until a tone pair has been acquired again, `est` is 0 and `code` is 0.
- R2: With both bands holding a valid tone, `code` follows the keypad. Rows are the low tones 697/770/852/941 Hz and columns are the high tones 1209/1336/1477/1633 Hz. Row 697 gives 1,2,3,A; row 770 gives 4,5,6,B; row 852 gives 7,8,9,C; row 941 gives *,0,#,D. Digits 1 to 9 encode as 1 to 9, 0 as 10, * as 11, # as 12, and A, B, C, D as 13, 14, 15, 0.
- R3: A tone whose frequency is off its nominal by up to ±(1.5% + 2 Hz) is accepted and decodes to the same key.
- R4: A tone whose frequency is off its nominal by 3.5% or more, in either direction, is rejected. `est` then stays 0.
- R5: If only one band carries a tone and the other is silent, `est` stays 0.
- R6: When one band's input stops toggling, `est` falls no later than that band's longest accepted period plus a few cycles after the last rising edge.
- R7: `code` is 0 whenever `est` is 0.
- R8: A band becomes valid only after NCYC consecutive in-window periods of the same tone. Its first rising edge after silence only starts the measurement. So with NCYC=3, `est` is still 0 when a pair has run for less than three full periods of its slower tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_sq | input | 1 | Squared low-group tone from the comparator |
| hi_sq | input | 1 | Squared high-group tone from the comparator |
| code | output | 4 | Key code of the detected pair, 0 when idle |
| est | output | 1 | Early steering: both bands hold a valid tone |

## Verification
The bench drives square waves at the frequencies that lie exactly on the accept and reject limits, on both sides of the nominal and in both bands. A window built the wrong way round, or one that is too narrow or too wide, would drop a key that must be accepted or pass one that must be rejected. It starts a pair from silence and samples it partway through acquisition. A decoder that trusted the first partial period, or that needed fewer periods, would raise steering early. It also silences one band while the other keeps running. A decoder with no timeout on a stopped input would hold steering and the stale code indefinitely. Finally, it walks all sixteen keys, so that a swapped row or column, or a wrong code for * # 0 D, shows up as a wrong code.

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder #(
  parameter int CLK_HZ     = 3579545,
  parameter int NCYC       = 4,
  parameter int WIN_PERMIL = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_sq,
  input  logic       hi_sq,
  output logic [3:0] code,
  output logic       est
);

  localparam int LO_F [4] = '{697, 770, 852, 941};
  localparam int HI_F [4] = '{1209, 1336, 1477, 1633};

  // period count (cycles) of a tone at f scaled by (1000 + d)/1000
  function automatic int per_lim(input int f, input int d);
    longint num;
    num = longint'(CLK_HZ) * 1000;
    return int'(num / (longint'(f) * longint'(1000 + d)));
  endfunction

  localparam int TOP_LO = per_lim(LO_F[0], -WIN_PERMIL);
  localparam int TOP_HI = per_lim(HI_F[0], -WIN_PERMIL);
  localparam int CW     = $clog2(TOP_LO + 2);
  localparam int RW     = $clog2(NCYC + 1);

  logic [1:0]    sq_in;
  logic [1:0]    rise;
  logic [1:0]    valid;
  logic [2:0]    sh    [2];
  logic [CW-1:0] cnt   [2];
  logic [RW-1:0] run   [2];
  logic [1:0]    cur   [2];
  logic [1:0]    armed;

  assign sq_in = {hi_sq, lo_sq};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam int TOP = (g == 0) ? TOP_LO : TOP_HI;
    logic [3:0] in_win;
    logic       hit;
    logic [1:0] idx;

    for (genvar t = 0; t < 4; t++) begin : g_tone
      localparam int F    = (g == 0) ? LO_F[t] : HI_F[t];
      localparam int LO_B = per_lim(F, WIN_PERMIL);
      localparam int HI_B = per_lim(F, -WIN_PERMIL);
      assign in_win[t] = (cnt[g] >= CW'(LO_B)) && (cnt[g] <= CW'(HI_B));
    end

    assign hit = |in_win;
    assign idx = {in_win[3] | in_win[2], in_win[3] | in_win[1]};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sh[g] <= '0;
      else        sh[g] <= {sh[g][1:0], sq_in[g]};

    assign rise[g] = sh[g][1] & ~sh[g][2];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt[g]   <= '0;
        run[g]   <= '0;
        cur[g]   <= '0;
        armed[g] <= 1'b0;
      end else if (rise[g]) begin
        cnt[g]   <= CW'(1);
        armed[g] <= 1'b1;
        if (armed[g] && hit) begin
          if (run[g] != '0 && idx == cur[g]) begin
            if (run[g] < RW'(NCYC)) run[g] <= run[g] + 1'b1;
          end else begin
            run[g] <= RW'(1);
            cur[g] <= idx;
          end
        end else begin
          run[g] <= '0;
        end
      end else begin
        if (cnt[g] <= CW'(TOP)) cnt[g] <= cnt[g] + 1'b1;
        if (cnt[g] >= CW'(TOP)) run[g] <= '0;
      end

    assign valid[g] = (run[g] >= RW'(NCYC));
  end

  logic [3:0] key;
  always_comb begin
    if (cur[1] == 2'd3)
      key = 4'd13 + {2'b00, cur[0]};
    else if (cur[0] == 2'd3)
      key = (cur[1] == 2'd0) ? 4'd11 : (cur[1] == 2'd1) ? 4'd10 : 4'd12;
    else
      key = 4'd3 * {2'b00, cur[0]} + {2'b00, cur[1]} + 4'd1;
  end

  assign est  = &valid;
  assign code = est ? key : 4'd0;

endmodule

// File: rtl/dtmf_pair_decoder_chk.sv
module dtmf_pair_decoder_chk #(
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          est,
  input logic [3:0]    code,
  input logic [1:0]    rise,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi
);

  // R1: no steering in the cycle after reset is seen
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !est);

  // R8: steering can only appear right after a measured edge
  p_est_after_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(est) |-> $past(|rise));

  // R6: a band whose counter has stalled (no edges) cannot hold steering
  p_silent_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cnt_lo) || $stable(cnt_hi)) |-> !est);

  // R2: code does not change while steering is held
  p_code_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (est && $past(est)) |-> $stable(code));

endmodule

bind dtmf_pair_decoder dtmf_pair_decoder_chk #(.CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .est    (est),
  .code   (code),
  .rise   (rise),
  .cnt_lo (cnt[0]),
  .cnt_hi (cnt[1])
);

// File: tb/dtmf_pair_decoder_bench.sv
`timescale 1ns/1ps
module dtmf_pair_decoder_bench;
  localparam int CLK_HZ = 600000;
  localparam int NCYC   = 3;

  localparam real LOW_HZ  [4] = '{697.0, 770.0, 852.0, 941.0};
  localparam real HIGH_HZ [4] = '{1209.0, 1336.0, 1477.0, 1633.0};
  localparam byte KEYPAD  [16] = '{"1","2","3","A","4","5","6","B",
                                   "7","8","9","C","*","0","#","D"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lo_sq = 1'b0;
  logic       hi_sq = 1'b0;
  logic [3:0] code;
  logic       est;

  int per_lo = 0, per_hi = 0, prev_max = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dtmf_pair_decoder #(.CLK_HZ(CLK_HZ), .NCYC(NCYC), .WIN_PERMIL(25)) u_dtmf_pair_decoder (
    .clk(clk), .rst_n(rst_n), .lo_sq(lo_sq), .hi_sq(hi_sq), .code(code), .est(est));

  function automatic int exp_code(byte ch);
    case (ch)
      "0": return 10;
      "*": return 11;
      "#": return 12;
      "A": return 13;
      "B": return 14;
      "C": return 15;
      "D": return 0;
      default: return int'(ch) - 48;
    endcase
  endfunction

  function automatic int per_of(real f);
    return int'(real'(CLK_HZ) / f);
  endfunction

  initial forever begin
    @(negedge clk);
    if (per_lo > 0) begin
      int p;
      p = per_lo;
      lo_sq = 1'b1;
      repeat (p / 2) @(negedge clk);
      lo_sq = 1'b0;
      repeat (p - p / 2 - 1) @(negedge clk);
    end
  end

  initial forever begin
    @(negedge clk);
    if (per_hi > 0) begin
      int p;
      p = per_hi;
      hi_sq = 1'b1;
      repeat (p / 2) @(negedge clk);
      hi_sq = 1'b0;
      repeat (p - p / 2 - 1) @(negedge clk);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic play(int pl, int ph);
    int m;
    m = (pl > ph) ? pl : ph;
    if (prev_max > m) m = prev_max;
    per_lo = pl;
    per_hi = ph;
    prev_max = (pl > ph) ? pl : ph;
    repeat ((NCYC + 2) * m + 40) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    chk("R1 est in reset", int'(est), 0);
    chk("R1 code in reset", int'(code), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 est after reset", int'(est), 0);

    // R8: pair 697/1209 from silence, sampled before three low periods elapse
    per_lo = per_of(LOW_HZ[0]);
    per_hi = per_of(HIGH_HZ[0]);
    prev_max = per_lo;
    repeat (2150) @(negedge clk);
    chk("R8 est early", int'(est), 0);
    chk("R7 code early", int'(code), 0);
    repeat (600) @(negedge clk);
    chk("R8 est acquired", int'(est), 1);
    chk("R8 code acquired", int'(code), 1);

    // R2: all sixteen keys
    for (int i = 0; i < 16; i++) begin
      play(per_of(LOW_HZ[i / 4]), per_of(HIGH_HZ[i % 4]));
      chk($sformatf("R2 est key %c", KEYPAD[i]), int'(est), 1);
      chk($sformatf("R2 code key %c", KEYPAD[i]), int'(code), exp_code(KEYPAD[i]));
    end

    // R3: accept limits
    play(per_of(LOW_HZ[1] * 1.015 + 2.0), per_of(HIGH_HZ[1] * 1.015 + 2.0));
    chk("R3 est key 5 high side", int'(est), 1);
    chk("R3 code key 5 high side", int'(code), 5);
    play(per_of(LOW_HZ[0] * 0.985 - 2.0), per_of(HIGH_HZ[3] * 1.015 + 2.0));
    chk("R3 est key A", int'(est), 1);
    chk("R3 code key A", int'(code), 13);
    play(per_of(LOW_HZ[3] * 1.015 + 2.0), per_of(HIGH_HZ[3] * 0.985 - 2.0));
    chk("R3 est key D", int'(est), 1);
    chk("R3 code key D", int'(code), 0);
    play(per_of(LOW_HZ[2] * 0.985 - 2.0), per_of(HIGH_HZ[0] * 0.985 - 2.0));
    chk("R3 code key 7 low side", int'(code), 7);

    // R4: reject limits
    play(per_of(LOW_HZ[2] * 1.035), per_of(HIGH_HZ[2]));
    chk("R4 est low +3.5%", int'(est), 0);
    chk("R7 code low +3.5%", int'(code), 0);
    play(per_of(LOW_HZ[2]), per_of(HIGH_HZ[2] * 0.965));
    chk("R4 est high -3.5%", int'(est), 0);
    play(per_of(LOW_HZ[0] * 0.965), per_of(HIGH_HZ[3] * 1.035));
    chk("R4 est both off", int'(est), 0);

    // R5: single band present
    play(per_of(LOW_HZ[1]), 0);
    chk("R5 est low only", int'(est), 0);
    chk("R7 code low only", int'(code), 0);
    play(0, per_of(HIGH_HZ[2]));
    chk("R5 est high only", int'(est), 0);

    // R6: low band stops while high keeps running
    play(per_of(LOW_HZ[3]), per_of(HIGH_HZ[1]));
    chk("R6 est key 0 before stop", int'(est), 1);
    chk("R6 code key 0 before stop", int'(code), 10);
    per_lo = 0;
    repeat (950) @(negedge clk);
    chk("R6 est after low stops", int'(est), 0);
    chk("R7 code after low stops", int'(code), 0);

    // R1: reset in the middle of a valid pair
    play(per_of(LOW_HZ[1]), per_of(HIGH_HZ[1]));
    chk("R1 est before mid reset", int'(est), 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 est mid reset", int'(est), 0);
    chk("R1 code mid reset", int'(code), 0);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule